// File: doc/BRIEF.md
# In-Order Load Return Unit

This block sits between the load issue point of an integer pipeline and the register file write port. Every load that issues is recorded in a small queue together with its access size, its signedness, its byte offset inside the doubleword and its tag. The data cache outcome comes with the load. A hit carries the doubleword at once. A miss leaves the entry waiting until a refill strobe delivers the doubleword. The block returns one result per cycle at most, always oldest first. Each result is a 64-bit value that is already sign- or zero-extended, together with the tag of its load.

Two timing classes exist. Ordinary loads return two cycles after issue. A signed load narrower than a doubleword returns three cycles after issue. Such a load also puts the unit into a slow-return mode, and every load that issues in the directly following cycles uses the three-cycle timing too, until a cycle passes with no load. A load whose offset is not a multiple of its size is not queued. It raises a trap strobe carrying its tag instead. The surrounding pipeline holds its load when the queue is full.

Top module: `ldr_return_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wb_valid` and `trap_valid` are 0 and `ld_ready` is 1.
- R2: A load accepted in cycle c that hits, is not a signed sub-doubleword load, and does not issue in slow-return mode, with nothing older pending, raises `wb_valid` with its tag in cycle c+2.
- R3: A signed load of byte, halfword or word size (`ld_signed`=1, `ld_size`≠3) that hits, with nothing older pending, returns in cycle c+3.
- R4: An aligned load accepted in the cycle right after a load that used three-cycle timing also uses three-cycle timing, whatever its own size and signedness; the chain continues for as long as aligned loads arrive in consecutive cycles.
- R5: After a cycle in which no aligned load is accepted, the next load uses the timing of its own class again.
- R6: Results return strictly in acceptance order. An entry returns in cycle max(c+latency, r+2, p+1), where r is the cycle of its refill strobe if it missed and p is the return cycle of the previous result. A miss therefore holds back every younger hit.
- R7: `fill_valid` delivers `fill_data` to the oldest queued load that still waits for data. A refill strobe while no queued load is waiting for data has no effect.
- R8: A load is misaligned if `ld_offset` is not a multiple of 2^`ld_size`. It is not queued, never writes back, raises `trap_valid` with its tag in cycle c+1, and counts as a cycle with no load for R5.
- R9: Sizes are encoded 0 byte, 1 halfword, 2 word, 3 doubleword. The field starts at bit 8·`ld_offset` of the doubleword, with lane order little-endian by default. It is sign-extended to 64 bits when `ld_signed`=1 and zero-extended otherwise.
- R10: With DEPTH loads queued, `ld_ready` is 0 and `ld_valid` is not accepted. The load is taken once a slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load issues this cycle |
| ld_ready | output | 1 | Queue can take a load |
| ld_tag | input | TAG_W | Destination tag of the load |
| ld_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| ld_signed | input | 1 | Sign-extend the loaded field |
| ld_offset | input | 3 | Byte offset inside the doubleword |
| ld_hit | input | 1 | The load hit the data cache |
| ld_hit_data | input | 64 | Doubleword read on a hit |
| fill_valid | input | 1 | Refill data for the oldest waiting miss |
| fill_data | input | 64 | Refilled doubleword |
| wb_valid | output | 1 | Result written back this cycle |
| wb_tag | output | TAG_W | Tag of the returned load |
| wb_data | output | 64 | Extended load result |
| trap_valid | output | 1 | Misaligned load trap |
| trap_tag | output | TAG_W | Tag of the trapping load |

## Verification
The bench builds the unit with TAG_W=6, DEPTH=4, the default two- and three-cycle latencies and little-endian lanes. With these values, a complete sweep of every size, signedness and offset takes 64 cases and brings every extension path and every alignment trap into reach. Four back-to-back misses are enough to fill the queue, so back-pressure can be reached with short sequences. The same small depth makes it possible to build slow-mode chains, gaps and misses waiting behind hits in only a few cycles, with every return cycle predicted from the max() rule.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   localparam int WORD_W = 64;
   localparam int OFF_W  = 3;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } ld_size_e;

   typedef struct packed {
      ld_size_e         size;
      logic             sgn;
      logic [OFF_W-1:0] off;
   } ld_fmt_t;

   // offset bits that must be zero for an access of this size
   function automatic logic misaligned(ld_size_e sz, logic [OFF_W-1:0] off);
      logic [OFF_W-1:0] mask;
      case (sz)
         SZ_BYTE: mask = 3'b000;
         SZ_HALF: mask = 3'b001;
         SZ_WORD: mask = 3'b011;
         default: mask = 3'b111;
      endcase
      return (off & mask) != '0;
   endfunction

   function automatic logic needs_slow(ld_size_e sz, logic sgn);
      return sgn && (sz != SZ_DWORD);
   endfunction

endpackage

// File: rtl/ldr_issue_ctl.sv
module ldr_issue_ctl
   import ldr_pkg::*;
#(
   parameter int TAG_W    = 4,
   parameter int LAT_HIT  = 2,
   parameter int LAT_SLOW = 3,
   parameter int WAIT_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  ld_fmt_t           fmt,
   input  logic [TAG_W-1:0]  tag,
   output logic              enq,
   output logic [WAIT_W-1:0] wait_init,
   output logic              trap_valid,
   output logic [TAG_W-1:0]  trap_tag
);

   logic bad;
   logic slow_mode;
   logic take_slow;

   assign bad       = misaligned(fmt.size, fmt.off);
   assign enq       = accept && !bad;
   assign take_slow = needs_slow(fmt.size, fmt.sgn) || slow_mode;
   // entries count down to the pop cycle; the output register adds one more
   assign wait_init = take_slow ? WAIT_W'(LAT_SLOW - 2) : WAIT_W'(LAT_HIT - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slow_mode  <= 1'b0;
         trap_valid <= 1'b0;
         trap_tag   <= '0;
      end else begin
         slow_mode  <= enq && take_slow;
         trap_valid <= accept && bad;
         if (accept && bad) trap_tag <= tag;
      end
   end

endmodule

// File: rtl/ldr_queue.sv
module ldr_queue
   import ldr_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DEPTH  = 4,
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [TAG_W-1:0]  push_tag,
   input  ld_fmt_t           push_fmt,
   input  logic              push_has,
   input  logic [WORD_W-1:0] push_data,
   input  logic [WAIT_W-1:0] push_wait,
   input  logic              fill_valid,
   input  logic [WORD_W-1:0] fill_data,
   output logic              ready,
   output logic              pop,
   output logic [TAG_W-1:0]  head_tag,
   output ld_fmt_t           head_fmt,
   output logic [WORD_W-1:0] head_data
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   logic [PW-1:0]     rd_ptr, wr_ptr;
   logic [CW-1:0]     count;
   logic [DEPTH-1:0]  e_v, e_has, fill_sel;
   logic [TAG_W-1:0]  e_tag  [DEPTH];
   ld_fmt_t           e_fmt  [DEPTH];
   logic [WORD_W-1:0] e_data [DEPTH];
   logic [WAIT_W-1:0] e_wait [DEPTH];

   assign ready = count < CW'(DEPTH);

   // oldest entry still lacking data receives the refill
   always_comb begin
      logic          found;
      logic [PW-1:0] idx;
      found    = 1'b0;
      fill_sel = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = rd_ptr + PW'(k);
         if (!found && e_v[idx] && !e_has[idx]) begin
            fill_sel[idx] = 1'b1;
            found         = 1'b1;
         end
      end
   end

   assign pop       = e_v[rd_ptr] && e_has[rd_ptr] && (e_wait[rd_ptr] == '0);
   assign head_tag  = e_tag[rd_ptr];
   assign head_fmt  = e_fmt[rd_ptr];
   assign head_data = e_data[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              v, has;
      logic [TAG_W-1:0]  tag;
      ld_fmt_t           fmt;
      logic [WORD_W-1:0] data;
      logic [WAIT_W-1:0] wcnt;
      logic              here_wr, here_rd;

      assign here_wr = push && (wr_ptr == PW'(i));
      assign here_rd = pop && (rd_ptr == PW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v    <= 1'b0;
            has  <= 1'b0;
            tag  <= '0;
            fmt  <= '0;
            data <= '0;
            wcnt <= '0;
         end else if (here_wr) begin
            v    <= 1'b1;
            has  <= push_has;
            tag  <= push_tag;
            fmt  <= push_fmt;
            data <= push_data;
            wcnt <= push_wait;
         end else begin
            if (here_rd) v <= 1'b0;
            if (wcnt != '0) wcnt <= wcnt - WAIT_W'(1);
            if (fill_valid && fill_sel[i]) begin
               data <= fill_data;
               has  <= 1'b1;
            end
         end
      end

      assign e_v[i]    = v;
      assign e_has[i]  = has;
      assign e_tag[i]  = tag;
      assign e_fmt[i]  = fmt;
      assign e_data[i] = data;
      assign e_wait[i] = wcnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

endmodule

// File: rtl/ldr_extend.sv
module ldr_extend
   import ldr_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  ld_fmt_t           fmt,
   input  logic [WORD_W-1:0] raw,
   output logic [WORD_W-1:0] value
);

   logic [3:0]        nbytes;
   logic [5:0]        shamt;
   logic [WORD_W-1:0] field;

   always_comb begin
      case (fmt.size)
         SZ_BYTE: nbytes = 4'd1;
         SZ_HALF: nbytes = 4'd2;
         SZ_WORD: nbytes = 4'd4;
         default: nbytes = 4'd8;
      endcase
   end

   if (BIG_ENDIAN) begin : g_be
      logic [3:0] lane;
      assign lane  = 4'd8 - {1'b0, fmt.off} - nbytes;
      assign shamt = {lane[2:0], 3'b000};
   end else begin : g_le
      assign shamt = {fmt.off, 3'b000};
   end

   assign field = raw >> shamt;

   always_comb begin
      case (fmt.size)
         SZ_BYTE: value = fmt.sgn ? {{56{field[7]}},  field[7:0]}  : {56'd0, field[7:0]};
         SZ_HALF: value = fmt.sgn ? {{48{field[15]}}, field[15:0]} : {48'd0, field[15:0]};
         SZ_WORD: value = fmt.sgn ? {{32{field[31]}}, field[31:0]} : {32'd0, field[31:0]};
         default: value = field;
      endcase
   end

endmodule

// File: rtl/ldr_return_unit.sv
module ldr_return_unit
   import ldr_pkg::*;
#(
   parameter int TAG_W      = 4,
   parameter int DEPTH      = 4,
   parameter int LAT_HIT    = 2,
   parameter int LAT_SLOW   = 3,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   output logic             ld_ready,
   input  logic [TAG_W-1:0] ld_tag,
   input  logic [1:0]       ld_size,
   input  logic             ld_signed,
   input  logic [2:0]       ld_offset,
   input  logic             ld_hit,
   input  logic [63:0]      ld_hit_data,
   input  logic             fill_valid,
   input  logic [63:0]      fill_data,
   output logic             wb_valid,
   output logic [TAG_W-1:0] wb_tag,
   output logic [63:0]      wb_data,
   output logic             trap_valid,
   output logic [TAG_W-1:0] trap_tag
);

   localparam int WAIT_W = $clog2(LAT_SLOW + 1);

   if (TAG_W < 1)                     begin : g_bad_tag   $error("TAG_W must be at least 1"); end
   if (DEPTH < 4)                     begin : g_bad_depth $error("DEPTH must be at least 4"); end
   if ((DEPTH & (DEPTH - 1)) != 0)    begin : g_bad_pow2  $error("DEPTH must be a power of two"); end
   if (LAT_HIT < 2)                   begin : g_bad_hit   $error("LAT_HIT must be at least 2"); end
   if (LAT_SLOW <= LAT_HIT)           begin : g_bad_slow  $error("LAT_SLOW must exceed LAT_HIT"); end

   ld_fmt_t           fmt_in, head_fmt;
   logic              accept, enq, pop;
   logic [WAIT_W-1:0] wait_init;
   logic [TAG_W-1:0]  head_tag;
   logic [WORD_W-1:0] head_data, ext_data;

   assign fmt_in = '{size: ld_size_e'(ld_size), sgn: ld_signed, off: ld_offset};
   assign accept = ld_valid && ld_ready;

   ldr_issue_ctl #(
      .TAG_W(TAG_W), .LAT_HIT(LAT_HIT), .LAT_SLOW(LAT_SLOW), .WAIT_W(WAIT_W)
   ) u_issue (
      .clk(clk), .rst_n(rst_n), .accept(accept), .fmt(fmt_in), .tag(ld_tag),
      .enq(enq), .wait_init(wait_init),
      .trap_valid(trap_valid), .trap_tag(trap_tag)
   );

   ldr_queue #(
      .TAG_W(TAG_W), .DEPTH(DEPTH), .WAIT_W(WAIT_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(enq), .push_tag(ld_tag), .push_fmt(fmt_in),
      .push_has(ld_hit), .push_data(ld_hit_data), .push_wait(wait_init),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .ready(ld_ready), .pop(pop),
      .head_tag(head_tag), .head_fmt(head_fmt), .head_data(head_data)
   );

   ldr_extend #(.BIG_ENDIAN(BIG_ENDIAN)) u_ext (
      .fmt(head_fmt), .raw(head_data), .value(ext_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_tag   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= pop;
         if (pop) begin
            wb_tag  <= head_tag;
            wb_data <= ext_data;
         end
      end
   end

endmodule

// File: rtl/ldr_return_chk.sv
module ldr_return_chk #(
   parameter int TAG_W = 4,
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_valid,
   input logic             ld_ready,
   input logic [TAG_W-1:0] ld_tag,
   input logic [1:0]       ld_size,
   input logic             ld_signed,
   input logic [2:0]       ld_offset,
   input logic             ld_hit,
   input logic             wb_valid,
   input logic [TAG_W-1:0] wb_tag,
   input logic             trap_valid,
   input logic [TAG_W-1:0] trap_tag
);

   localparam int CW = $clog2(DEPTH) + 2;

   logic          odd, took_ok, took_bad, narrow, mode_q;
   logic [CW-1:0] live;

   always_comb begin
      case (ld_size)
         2'd0:    odd = 1'b0;
         2'd1:    odd = ld_offset[0];
         2'd2:    odd = |ld_offset[1:0];
         default: odd = |ld_offset;
      endcase
   end

   assign took_ok  = ld_valid && ld_ready && !odd;
   assign took_bad = ld_valid && ld_ready && odd;
   assign narrow   = ld_signed && (ld_size != 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= '0;
         mode_q <= 1'b0;
      end else begin
         live   <= live + CW'(took_ok) - CW'(wb_valid);
         mode_q <= took_ok && (narrow || mode_q);
      end
   end

   // R2: lone fast hit writes back two cycles later
   a_r2_fast_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (took_ok && ld_hit && !narrow && !mode_q && live == '0)
      |=> ##1 (wb_valid && wb_tag == $past(ld_tag, 2)));

   // R3: lone signed narrow hit is silent at +2 and returns at +3
   a_r3_slow_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (took_ok && ld_hit && narrow && live == '0)
      |=> ##1 !wb_valid ##1 (wb_valid && wb_tag == $past(ld_tag, 3)));

   // R8: misaligned load traps next cycle with its tag
   a_r8_trap_next: assert property (@(posedge clk) disable iff (!rst_n)
      took_bad |=> (trap_valid && trap_tag == $past(ld_tag)));

   a_r8_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $past(took_bad));

   // R10: a full queue refuses, an empty one accepts
   a_r10_full_only: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ready |-> (live == CW'(DEPTH)));

   a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (live == '0) |-> ld_ready);

   // R6: nothing returns that was not accepted
   a_r6_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (live != '0));

endmodule

bind ldr_return_unit ldr_return_chk #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
   .ld_tag(ld_tag), .ld_size(ld_size), .ld_signed(ld_signed),
   .ld_offset(ld_offset), .ld_hit(ld_hit), .wb_valid(wb_valid),
   .wb_tag(wb_tag), .trap_valid(trap_valid), .trap_tag(trap_tag)
);

// File: tb/sim_ldr_return_unit.sv
`timescale 1ns/1ps
module sim_ldr_return_unit;

   localparam int TW = 6;
   localparam int DP = 4;
   localparam int NQ = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 1'b0, ld_signed = 1'b0, ld_hit = 1'b0, fill_valid = 1'b0;
   logic [TW-1:0] ld_tag = '0;
   logic [1:0]    ld_size = '0;
   logic [2:0]    ld_offset = '0;
   logic [63:0]   ld_hit_data = '0, fill_data = '0;
   logic          ld_ready, wb_valid, trap_valid;
   logic [TW-1:0] wb_tag, trap_tag;
   logic [63:0]   wb_data;

   always #2 clk = ~clk;

   ldr_return_unit #(.TAG_W(TW), .DEPTH(DP)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
      .ld_tag(ld_tag), .ld_size(ld_size), .ld_signed(ld_signed),
      .ld_offset(ld_offset), .ld_hit(ld_hit), .ld_hit_data(ld_hit_data),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .trap_valid(trap_valid), .trap_tag(trap_tag)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   // expected-result queue
   int          q_tag [NQ], q_issue [NQ], q_lat [NQ], q_fill [NQ], q_sz [NQ], q_off [NQ];
   bit          q_sg  [NQ];
   logic [63:0] q_raw [NQ];
   string       q_req [NQ];
   int qh = 0, qt = 0, last_ret = -10;
   int t_cyc = -1, t_tag = 0;
   string t_req = "";
   bit mode_prev = 1'b0;
   string cur_req = "R2";

   task automatic note(string req, bit ok, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ext(logic [63:0] raw, int sz, bit sg, int off);
      int nb;
      logic [63:0] f, m;
      nb = 1 << sz;
      f  = raw >> (off * 8);
      if (nb == 8) return f;
      m = (64'd1 << (nb * 8)) - 64'd1;
      f = f & m;
      if (sg && f[nb*8-1]) f = f | ~m;
      return f;
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic check_outputs();
      bit exp_wb;
      int due;
      logic [63:0] ev;
      exp_wb = 1'b0;
      if (qh < qt && q_fill[qh] != -1) begin
         due = imax(imax(q_issue[qh] + q_lat[qh], q_fill[qh] + 2), last_ret + 1);
         exp_wb = (due == cyc);
      end
      if (exp_wb) begin
         ev = ext(q_raw[qh], q_sz[qh], q_sg[qh], q_off[qh]);
         note(q_req[qh], wb_valid && wb_tag == TW'(q_tag[qh]) && wb_data == ev,
              "writeback tag/data", {57'd0, wb_valid, wb_tag}, {57'd1, TW'(q_tag[qh])});
         note(q_req[qh], wb_data == ev, "writeback data", wb_data, ev);
         qh++;
         last_ret = cyc;
      end else if (wb_valid) begin
         note(cur_req, 1'b0, "unexpected writeback tag", {58'd0, wb_tag}, 64'd0);
      end
      if (t_cyc == cyc) begin
         note(t_req, trap_valid && trap_tag == TW'(t_tag), "trap tag",
              {57'd0, trap_valid, trap_tag}, {57'd1, TW'(t_tag)});
         t_cyc = -1;
      end else if (trap_valid) begin
         note(cur_req, 1'b0, "unexpected trap tag", {58'd0, trap_tag}, 64'd0);
      end
   endtask

   task automatic step(bit v, int tag, int sz, bit sg, int off, bit hit,
                       logic [63:0] d, bit fv, logic [63:0] fd);
      bit acc, bad, slow;
      @(negedge clk);
      check_outputs();
      if (fv) begin
         for (int k = qh; k < qt; k++) begin
            if (q_fill[k] == -1) begin
               q_fill[k] = cyc;
               q_raw[k]  = fd;
               break;
            end
         end
      end
      acc = v && ld_ready;
      bad = (off % (1 << sz)) != 0;
      if (acc && !bad) begin
         slow = (sg && sz != 3) || mode_prev;
         q_tag[qt] = tag; q_issue[qt] = cyc; q_lat[qt] = slow ? 3 : 2;
         q_fill[qt] = hit ? -1000 : -1; q_raw[qt] = d;
         q_sz[qt] = sz; q_sg[qt] = sg; q_off[qt] = off; q_req[qt] = cur_req;
         qt++;
         mode_prev = slow;
      end else begin
         mode_prev = 1'b0;
      end
      if (acc && bad) begin
         t_cyc = cyc + 1; t_tag = tag; t_req = cur_req;
      end
      ld_valid    = v;
      ld_tag      = TW'(tag);
      ld_size     = 2'(sz);
      ld_signed   = sg;
      ld_offset   = 3'(off);
      ld_hit      = hit;
      ld_hit_data = hit ? d : 64'hDEAD_BEEF_0BAD_F00D;
      fill_valid  = fv;
      fill_data   = fd;
   endtask

   task automatic ld(int tag, int sz, bit sg, int off, bit hit, logic [63:0] d);
      step(1'b1, tag, sz, sg, off, hit, d, 1'b0, 64'd0);
   endtask

   task automatic refill(logic [63:0] fd);
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 64'd0, 1'b1, fd);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, 64'd0, 1'b0, 64'd0);
   endtask

   localparam logic [63:0] PAT = 64'h80FF_7F01_8E72_C3A5;

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet outputs under reset
      note("R1", !wb_valid && !trap_valid && ld_ready, "reset outputs",
           {61'd0, wb_valid, trap_valid, ld_ready}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      note("R1", !wb_valid && !trap_valid && ld_ready, "after reset outputs",
           {61'd0, wb_valid, trap_valid, ld_ready}, 64'd1);

      // R9 sweep over size, sign, offset; misaligned ones trap (R8)
      for (int sz = 0; sz < 4; sz++)
         for (int sg = 0; sg < 2; sg++)
            for (int off = 0; off < 8; off++) begin
               int idx;
               logic [63:0] d;
               idx = sz * 16 + sg * 8 + off;
               d = (PAT << ((idx % 8) * 8)) | (PAT >> (64 - (idx % 8) * 8));
               if ((off % (1 << sz)) != 0)   cur_req = "R8";
               else if (sg == 1 && sz != 3)  cur_req = "R3/R9";
               else                          cur_req = "R2/R9";
               ld(idx % 64, sz, sg[0], off, 1'b1, d);
               idle(3);
            end

      // R4: chain of back-to-back loads after a signed half
      cur_req = "R4";
      ld(1, 1, 1'b1, 2, 1'b1, 64'h1122_F344_5566_7788);
      ld(2, 3, 1'b0, 0, 1'b1, 64'h0102_0304_0506_0708);
      ld(3, 2, 1'b0, 4, 1'b1, 64'hA1A2_A3A4_B1B2_B3B4);
      ld(4, 0, 1'b0, 7, 1'b1, 64'hC700_0000_0000_0000);
      idle(1);
      cur_req = "R5";
      ld(5, 3, 1'b0, 0, 1'b1, 64'h5555_AAAA_5555_AAAA);
      idle(5);
      cur_req = "R4";
      ld(6, 2, 1'b0, 0, 1'b1, 64'h0000_0001_8000_0000);
      ld(7, 2, 1'b1, 0, 1'b1, 64'h0000_0001_8000_0000);
      ld(8, 1, 1'b0, 6, 1'b1, 64'hFEDC_0000_0000_0000);
      idle(6);

      // R8 inside a chain ends slow mode (R5)
      cur_req = "R5";
      ld(9, 2, 1'b1, 0, 1'b1, 64'h0000_0000_F000_0001);
      ld(10, 1, 1'b0, 1, 1'b1, 64'h0);
      ld(11, 0, 1'b0, 3, 1'b1, 64'h0000_0000_9900_0000);
      idle(6);

      // R6: a miss holds back younger hits
      cur_req = "R6";
      ld(12, 3, 1'b0, 0, 1'b0, 64'h0);
      ld(13, 2, 1'b0, 0, 1'b1, 64'h0000_0000_1234_5678);
      ld(14, 0, 1'b1, 5, 1'b1, 64'h0000_8100_0000_0000);
      idle(4);
      refill(64'h0F0E_0D0C_0B0A_0908);
      idle(6);
      ld(15, 2, 1'b0, 4, 1'b0, 64'h0);
      ld(16, 3, 1'b0, 0, 1'b1, 64'h7777_6666_5555_4444);
      ld(17, 1, 1'b1, 2, 1'b0, 64'h0);
      idle(2);
      refill(64'h89AB_CDEF_0000_0000);
      idle(3);
      refill(64'h0000_0000_8001_0000);
      idle(6);

      // R7: stray refill ignored, later refill reaches the waiting miss
      cur_req = "R7";
      refill(64'hBAD0_BAD0_BAD0_BAD0);
      idle(2);
      ld(18, 3, 1'b0, 0, 1'b1, 64'h1357_9BDF_2468_ACE0);
      refill(64'hBAD1_BAD1_BAD1_BAD1);
      ld(19, 3, 1'b0, 0, 1'b0, 64'h0);
      idle(3);
      refill(64'h600D_600D_600D_600D);
      idle(6);

      // R10: four misses fill the queue, a fifth waits
      cur_req = "R10";
      ld(20, 3, 1'b0, 0, 1'b0, 64'h0);
      ld(21, 3, 1'b0, 0, 1'b0, 64'h0);
      ld(22, 3, 1'b0, 0, 1'b0, 64'h0);
      ld(23, 3, 1'b0, 0, 1'b0, 64'h0);
      ld(24, 3, 1'b0, 0, 1'b1, 64'h2424_2424_2424_2424);
      note("R10", ld_ready == 1'b0, "ready with full queue", {63'd0, ld_ready}, 64'd0);
      idle(2);
      refill(64'h2020_2020_2020_2020);
      refill(64'h2121_2121_2121_2121);
      idle(2);
      note("R10", ld_ready == 1'b1, "ready after slots free", {63'd0, ld_ready}, 64'd1);
      ld(24, 3, 1'b0, 0, 1'b1, 64'h2424_2424_2424_2424);
      refill(64'h2222_2222_2222_2222);
      refill(64'h2323_2323_2323_2323);
      idle(8);

      note("R6", qh == qt, "results still pending", 64'(qt - qh), 64'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not finish actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule